// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt Controller

This block sits beside a pair of analog comparators and turns changes in their digital results into interrupt flags. Each raw comparator bit passes through a per-channel polarity control before anything else sees it. The polarity-adjusted result is captured in two places. A snapshot holder loads it whenever software reads or writes the status register. A sampler loads it on each phase-one strobe of the instruction cycle. When the two disagree, the channel is in mismatch, and its flag is forced to 1.

Software finds out which comparator moved by reading the status register, which also re-arms detection. It then clears the flag by writing 0 to the flag register. A clear has no lasting effect while a mismatch persists. Writing 1 to a flag raises a simulated interrupt. The request line combines the flags with per-channel enables, a peripheral enable and a global enable. Flags still record changes while the request is masked.

Top module: `cmp_chg_irq`

## Requirements
- R1: After reset, both flags are 0, both invert bits are 0, the request is low, and the snapshot and sampled copies are 0.
- R2: The visible output of channel i is the raw bit XOR the invert bit of channel i. A status-register write loads the invert bits from write data bits 5:4, with bit 4 for channel 0. The status read value carries the outputs in bits 7:6 (bit 6 = channel 0), the invert bits in bits 5:4 and zeros in bits 3:0.
- R3: The sampled copy updates only on a phase-one strobe. A change of output with no strobe and no status access sets no flag. After the strobe edge that samples a changed output, the flag is 1 one clock later.
- R4: While the sampled copy differs from the snapshot, the flag is set on every clock. A flag write of 0 in that state leaves the flag at 1, because set wins over clear.
- R5: A status-register read loads the snapshot with the current output and ends the mismatch. A later clear then holds.
- R6: A status-register write performs the same snapshot load as a read.
- R7: When the sampled output returns to the snapshot value, the mismatch ends. The flag stays 1 until software clears it, and the clear then holds.
- R8: A flag-register write of 1 to bit i sets flag i (simulated interrupt).
- R9: The request is high only when global enable and peripheral enable are both 1 and at least one channel has both its flag and its enable at 1. Flags are unaffected by the enables.
- R10: The flag read value carries flag i in bit i, with all higher bits 0.
- R11: A flag-register write of 0 with no mismatch clears the flag on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 2 | Raw comparator results, bit i = channel i |
| ph1_stb | input | 1 | Phase-one strobe; the sampled copy loads when high |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| flag_wr | input | 1 | Flag register write strobe |
| wdata | input | 8 | Write data for both registers |
| ch_en | input | 2 | Per-channel request enables |
| periph_en | input | 1 | Peripheral request enable |
| global_en | input | 1 | Global request enable |
| stat_rdata | output | 8 | Status read value |
| flag_rdata | output | 8 | Flag read value |
| cmp_out | output | 2 | Polarity-adjusted comparator outputs |
| flags | output | 2 | Interrupt flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The following paths are combinational and are checked in the same half cycle as the stimulus: the polarity result, both read values and the request. The invert bits and a flag write land at the clock edge of the strobe. A change seen by a phase-one strobe reaches the flag one edge after the strobe edge, because the mismatch comes from two registers and the flag is a third. The bench drives every input just after a falling edge and samples just after the next falling edge. It counts edges exactly, so each flag check lands in the first cycle in which the flag may have moved. It also checks one cycle earlier, where the flag must not yet have changed.

// File: rtl/cce_pkg.sv
package cce_pkg;
  localparam int unsigned CCE_NCH = 2;
  localparam int unsigned CCE_DW  = 8;

  // polarity-adjusted comparator result
  function automatic logic pol_bit(input logic raw, input logic inv);
    return raw ^ inv;
  endfunction

  // one channel's contribution to the request before the common gates
  function automatic logic req_term(input logic flag, input logic en);
    return flag & en;
  endfunction

  // next flag value: software write first, mismatch set wins
  function automatic logic flag_next(input logic cur, input logic wr,
                                     input logic wbit, input logic set);
    return (wr ? wbit : cur) | set;
  endfunction
endpackage

// File: rtl/cce_detect.sv
module cce_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic inv,
  input  logic ph1_stb,
  input  logic snap_ld,
  output logic out,
  output logic snap_q,
  output logic samp_q,
  output logic mismatch
);
  import cce_pkg::*;

  assign out = pol_bit(raw, inv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= 1'b0;
    end else if (snap_ld) begin
      snap_q <= out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
    end else if (ph1_stb) begin
      samp_q <= out;
    end
  end

  assign mismatch = snap_q ^ samp_q;
endmodule

// File: rtl/cce_flag.sv
module cce_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wbit,
  input  logic set,
  output logic flag_q
);
  import cce_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_next(flag_q, wr, wbit, set);
    end
  end
endmodule

// File: rtl/cce_ctrl.sv
module cce_ctrl #(
  parameter int unsigned NCH = cce_pkg::CCE_NCH,
  parameter int unsigned DW  = cce_pkg::CCE_DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stat_wr,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] out_vec,
  input  logic [NCH-1:0] flag_vec,
  input  logic [NCH-1:0] ch_en,
  input  logic           periph_en,
  input  logic           global_en,
  output logic [NCH-1:0] inv_q,
  output logic [DW-1:0]  stat_rdata,
  output logic [DW-1:0]  flag_rdata,
  output logic           irq
);
  import cce_pkg::*;

  localparam int unsigned OUT_HI = DW - 1;
  localparam int unsigned INV_HI = DW - NCH - 1;
  localparam int unsigned INV_LO = DW - 2 * NCH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_q <= '0;
    end else if (stat_wr) begin
      inv_q <= wdata[INV_HI:INV_LO];
    end
  end

  always_comb begin
    stat_rdata = '0;
    stat_rdata[OUT_HI -: NCH] = out_vec;
    stat_rdata[INV_HI -: NCH] = inv_q;
  end

  always_comb begin
    flag_rdata = '0;
    flag_rdata[NCH-1:0] = flag_vec;
  end

  logic any_req;
  always_comb begin
    any_req = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      any_req = any_req | req_term(flag_vec[i], ch_en[i]);
    end
  end

  assign irq = any_req & periph_en & global_en;
endmodule

// File: rtl/cmp_chg_irq.sv
module cmp_chg_irq #(
  parameter int unsigned NCH = cce_pkg::CCE_NCH,
  parameter int unsigned DW  = cce_pkg::CCE_DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cmp_raw,
  input  logic           ph1_stb,
  input  logic           stat_rd,
  input  logic           stat_wr,
  input  logic           flag_wr,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] ch_en,
  input  logic           periph_en,
  input  logic           global_en,
  output logic [DW-1:0]  stat_rdata,
  output logic [DW-1:0]  flag_rdata,
  output logic [NCH-1:0] cmp_out,
  output logic [NCH-1:0] flags,
  output logic           irq
);
  // named internal events for the checker
  logic           snap_ld;
  logic [NCH-1:0] inv_q;
  logic [NCH-1:0] snap_q;
  logic [NCH-1:0] samp_q;
  logic [NCH-1:0] mismatch;

  // a write includes an implicit read
  assign snap_ld = stat_rd | stat_wr;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cce_detect u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (cmp_raw[g]),
      .inv      (inv_q[g]),
      .ph1_stb  (ph1_stb),
      .snap_ld  (snap_ld),
      .out      (cmp_out[g]),
      .snap_q   (snap_q[g]),
      .samp_q   (samp_q[g]),
      .mismatch (mismatch[g])
    );

    cce_flag u_flg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (flag_wr),
      .wbit   (wdata[g]),
      .set    (mismatch[g]),
      .flag_q (flags[g])
    );
  end

  cce_ctrl #(.NCH(NCH), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_wr    (stat_wr),
    .wdata      (wdata),
    .out_vec    (cmp_out),
    .flag_vec   (flags),
    .ch_en      (ch_en),
    .periph_en  (periph_en),
    .global_en  (global_en),
    .inv_q      (inv_q),
    .stat_rdata (stat_rdata),
    .flag_rdata (flag_rdata),
    .irq        (irq)
  );

  logic unused_wbits;
  assign unused_wbits = ^{wdata, snap_q, samp_q};
endmodule

// File: rtl/cce_checker.sv
module cce_checker #(
  parameter int unsigned NCH = 2,
  parameter int unsigned DW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ph1_stb,
  input logic           stat_rd,
  input logic           stat_wr,
  input logic           flag_wr,
  input logic [DW-1:0]  wdata,
  input logic [NCH-1:0] mismatch,
  input logic [NCH-1:0] flags,
  input logic [NCH-1:0] cmp_out,
  input logic [DW-1:0]  stat_rdata,
  input logic [DW-1:0]  flag_rdata,
  input logic           periph_en,
  input logic           global_en,
  input logic           irq
);
  a_r2_status_layout: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[DW-1 -: NCH] == cmp_out) && (stat_rdata[DW-2*NCH-1:0] == '0));

  a_r3_no_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ph1_stb) && !$past(stat_rd) && !$past(stat_wr)) |-> $stable(mismatch));

  a_r4_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|mismatch) |=> ((flags & $past(mismatch)) == $past(mismatch)));

  a_r5_read_and_sample_align: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && ph1_stb) |=> (mismatch == '0));

  a_r8_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> ((flags & $past(wdata[NCH-1:0])) == $past(wdata[NCH-1:0])));

  a_r9_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!global_en || !periph_en) |-> !irq);

  a_r10_flag_layout: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rdata[NCH-1:0] == flags) && (flag_rdata[DW-1:NCH] == '0));

  a_r11_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && ((wdata[NCH-1:0] | mismatch) == '0)) |=> (flags == '0));
endmodule

bind cmp_chg_irq cce_checker #(.NCH(NCH), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ph1_stb    (ph1_stb),
  .stat_rd    (stat_rd),
  .stat_wr    (stat_wr),
  .flag_wr    (flag_wr),
  .wdata      (wdata),
  .mismatch   (mismatch),
  .flags      (flags),
  .cmp_out    (cmp_out),
  .stat_rdata (stat_rdata),
  .flag_rdata (flag_rdata),
  .periph_en  (periph_en),
  .global_en  (global_en),
  .irq        (irq)
);

// File: tb/tb_cmp_chg_irq.sv
`timescale 1ns/1ps
module tb_cmp_chg_irq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cmp_raw;
  logic       ph1_stb, stat_rd, stat_wr, flag_wr;
  logic [7:0] wdata;
  logic [1:0] ch_en;
  logic       periph_en, global_en;
  logic [7:0] stat_rdata, flag_rdata;
  logic [1:0] cmp_out, flags;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_chg_irq dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .ph1_stb(ph1_stb),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .flag_wr(flag_wr), .wdata(wdata),
    .ch_en(ch_en), .periph_en(periph_en), .global_en(global_en),
    .stat_rdata(stat_rdata), .flag_rdata(flag_rdata), .cmp_out(cmp_out),
    .flags(flags), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic strobe();
    ph1_stb = 1'b1; tick(); ph1_stb = 1'b0;
  endtask

  task automatic fwrite(input logic [7:0] d);
    flag_wr = 1'b1; wdata = d; tick(); flag_wr = 1'b0; wdata = '0;
  endtask

  task automatic swrite(input logic [7:0] d);
    stat_wr = 1'b1; wdata = d; tick(); stat_wr = 1'b0; wdata = '0;
  endtask

  task automatic resync();
    ph1_stb = 1'b1; stat_rd = 1'b1; tick();
    ph1_stb = 1'b0; stat_rd = 1'b0;
    fwrite(8'h00);
    tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cmp_raw = 2'b01;
    ph1_stb = 0; stat_rd = 0; stat_wr = 0; flag_wr = 0; wdata = '0;
    ch_en = '0; periph_en = 0; global_en = 0;
    repeat (3) tick();
    chk("R1 flags", {6'b0, flags}, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 status with raw=01", stat_rdata, 8'h40);
    cmp_raw = 2'b00;
    tick(); rst_n = 1'b1; tick();
    chk("R1 status after release", stat_rdata, 8'h00);
    chk("R10 flag read after reset", flag_rdata, 8'h00);
  endtask

  task automatic t_sample_only_on_strobe();
    cmp_raw = 2'b01;
    repeat (3) tick();
    chk("R3 no strobe no flag", {6'b0, flags}, 8'h00);
    strobe();
    chk("R3 flag not yet", {6'b0, flags}, 8'h00);
    tick();
    chk("R3 flag one edge after strobe", {6'b0, flags}, 8'h01);
    chk("R9 masked request", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_persist();
    fwrite(8'h00);
    chk("R4 clear during mismatch", {6'b0, flags}, 8'h01);
    tick();
    chk("R4 still set", {6'b0, flags}, 8'h01);
  endtask

  task automatic t_read_rearms();
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    fwrite(8'h00);
    chk("R5 clear after read", {6'b0, flags}, 8'h00);
    tick();
    chk("R5 clear holds", {6'b0, flags}, 8'h00);
  endtask

  task automatic t_return();
    cmp_raw = 2'b11; strobe(); tick();
    chk("R7 ch1 flag set", {6'b0, flags}, 8'h02);
    cmp_raw = 2'b01; strobe(); tick();
    chk("R7 flag sticky after return", {6'b0, flags}, 8'h02);
    fwrite(8'h00);
    chk("R7 clear after return", {6'b0, flags}, 8'h00);
    tick();
    chk("R7 clear holds", {6'b0, flags}, 8'h00);
  endtask

  task automatic t_write_rearms();
    cmp_raw = 2'b00; strobe(); tick();
    chk("R6 change flagged", {6'b0, flags}, 8'h01);
    swrite(8'h00);
    fwrite(8'h00);
    chk("R6 clear after write", {6'b0, flags}, 8'h00);
    tick();
    chk("R6 clear holds", {6'b0, flags}, 8'h00);
  endtask

  task automatic t_polarity();
    swrite(8'h30);
    chk("R2 inverted outputs", {6'b0, cmp_out}, 8'h03);
    chk("R2 status read", stat_rdata, 8'hF0);
    cmp_raw = 2'b01; #1;
    chk("R2 mixed polarity status", stat_rdata, 8'hB0);
    swrite(8'h10);
    chk("R2 ch0 invert only", {6'b0, cmp_out}, 8'h00);
    chk("R2 status ch0 invert", stat_rdata, 8'h10);
    swrite(8'h00);
    cmp_raw = 2'b00;
    resync();
    chk("R11 clear with no mismatch", {6'b0, flags}, 8'h00);
  endtask

  task automatic t_soft_set();
    fwrite(8'h02);
    chk("R8 simulated set", {6'b0, flags}, 8'h02);
    chk("R10 flag read layout", flag_rdata, 8'h02);
    tick();
    chk("R8 set persists", {6'b0, flags}, 8'h02);
  endtask

  task automatic t_gating();
    ch_en = 2'b10; periph_en = 1; global_en = 0; #1;
    chk("R9 global off", {7'b0, irq}, 8'h00);
    global_en = 1; #1;
    chk("R9 all on", {7'b0, irq}, 8'h01);
    periph_en = 0; #1;
    chk("R9 periph off", {7'b0, irq}, 8'h00);
    periph_en = 1; ch_en = 2'b01; #1;
    chk("R9 other channel enabled", {7'b0, irq}, 8'h00);
    ch_en = 2'b11; #1;
    chk("R9 both enabled", {7'b0, irq}, 8'h01);
    fwrite(8'h00);
    chk("R11 clear drops request", {6'b0, flags, irq}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_sample_only_on_strobe();
    t_persist();
    t_read_rearms();
    t_return();
    t_write_rearms();
    t_polarity();
    t_soft_set();
    t_gating();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule